// File: doc/BRIEF.md
# Priority interrupt controller core

This block takes eight interrupt request lines and decides which of them, if any, the processor should service next. A rising edge on a line records a pending request. The block masks requests, ranks them under a priority order that software can rotate, and drives a single interrupt output. The output is high while the best unmasked pending request outranks every level already in service. An acknowledge strobe, or a read that follows a poll command, moves the winning level from pending to in-service.

Software reaches the block through a byte-wide write/read port with one address bit. The odd address holds the mask register. Writes to the even address are command bytes, told apart by data bits 4:3. Bits 4:3 = 00 is an end-of-service/priority command. Bits 4:3 = 01 is a mode/read-select command. Any other value is ignored. Line 2 is the path from a downstream controller, so masking level 2 silences that whole downstream group.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask, request and in-service registers are all zero, level 0 ranks highest and level 7 lowest, even-address reads return the request register, special mask mode and poll are off, and `int_o` is low.
- R2: A write with `addr_i`=1 loads `wdata_i` into the mask register (1 = level masked). A non-poll read with `addr_i`=1 returns the mask register.
- R3: A 0-to-1 transition on `irq_i[n]` sets request bit n, even while level n is masked. A line held high raises no further request once that bit has been cleared.
- R4: Outside special mask mode, `int_o` is high exactly when some unmasked request exists and the best of them ranks strictly above every in-service level. `ack_lvl_o` gives that request's level.
- R5: `ack_i` while `int_o` is high sets the in-service bit of the level on `ack_lvl_o` and clears its request bit.
- R6: An even-address byte with bits 4:3 = 00 is a priority command whose code is bits 7:5. Code 001 clears the in-service bit of highest rank. Code 101 does the same and then makes that level the lowest.
- R7: Code 011 clears the in-service bit of the level in bits 2:0. Code 111 does the same and also makes that level the lowest.
- R8: Code 110 makes the level in bits 2:0 the lowest without touching any in-service bit. After any rotation the next level up (mod 8) ranks highest.
- R9: Codes 000, 010 and 100 leave all state unchanged. Even-address bytes with bits 4:3 = 1x are ignored.
- R10: An even-address byte with bits 4:3 = 01 is a mode command. Bits 6:5 = 11 enter special mask mode, 10 leave it, and 0x keep it. In that mode in-service levels block no other level; only unmasked requests not in service are candidates.
- R11: A mode command with bit 2 set arms a poll. The next read returns bit 7 = 1 and the level in bits 2:0 when an interrupt is due, and 0x00 otherwise. That read also acknowledges the level as in R5 and disarms the poll.
- R12: In a mode command, bits 1:0 = 10 select the request register for even-address reads, 11 select the in-service register, and 0x keep the selection.
- R13: Setting mask bit 2 blocks every interrupt arriving on the downstream-controller line 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Interrupt request lines, rising-edge sensitive |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 1 | Register address bit |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| int_o | output | 1 | Interrupt request to the processor |
| ack_lvl_o | output | 3 | Level to be serviced next |

## Verification
The resolver is driven with request sets of two or more levels under the reset order, under an order rotated by end-of-service and under an order set explicitly. These show whether rank follows the rotation or the raw index. Each set is combined with in-service levels that rank above, below and equal to the request, which separates correct blocking from blocking that is too loose or too strict. A level is latched while masked and unmasked later, and another line is held high across a service cycle, to separate edge capture from level sensing. Poll reads with and without a due request, and the three no-op codes, check that only the intended state moves.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  localparam int DW     = 8;
  localparam int NL     = 8;
  localparam int LW     = $clog2(NL);

  typedef enum logic [2:0] {
    PRI_AUTO_CLR = 3'b000,
    PRI_NS_EOI   = 3'b001,
    PRI_NOP      = 3'b010,
    PRI_SP_EOI   = 3'b011,
    PRI_AUTO_SET = 3'b100,
    PRI_ROT_NS   = 3'b101,
    PRI_SET_LOW  = 3'b110,
    PRI_ROT_SP   = 3'b111
  } pri_code_e;

  typedef struct packed {
    logic          mask_we;
    logic          eoi_ns;
    logic          eoi_sp;
    logic          rot;
    logic          set_low;
    logic [LW-1:0] lvl;
    logic          smm_set;
    logic          smm_clr;
    logic          poll_arm;
    logic          rsel_we;
    logic          rsel_isr;
  } pic_cmd_t;
endpackage

// File: rtl/pic_cmd_decode.sv
`timescale 1ns/1ps
module pic_cmd_decode
  import pic_pkg::*;
(
  input  logic          wr_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output pic_cmd_t      cmd_o
);
  pri_code_e code;
  assign code = pri_code_e'(wdata_i[7:5]);

  always_comb begin
    cmd_o     = '0;
    cmd_o.lvl = wdata_i[LW-1:0];
    if (wr_i) begin
      if (addr_i) begin
        cmd_o.mask_we = 1'b1;
      end else begin
        unique case (wdata_i[4:3])
          2'b00: begin
            unique case (code)
              PRI_NS_EOI:  cmd_o.eoi_ns = 1'b1;
              PRI_SP_EOI:  cmd_o.eoi_sp = 1'b1;
              PRI_ROT_NS:  begin cmd_o.eoi_ns = 1'b1; cmd_o.rot = 1'b1; end
              PRI_ROT_SP:  begin cmd_o.eoi_sp = 1'b1; cmd_o.rot = 1'b1; end
              PRI_SET_LOW: cmd_o.set_low = 1'b1;
              default: ; // auto-EOI rotate codes and nop do nothing
            endcase
          end
          2'b01: begin
            cmd_o.smm_set  = wdata_i[6] &  wdata_i[5];
            cmd_o.smm_clr  = wdata_i[6] & ~wdata_i[5];
            cmd_o.poll_arm = wdata_i[2];
            cmd_o.rsel_we  = wdata_i[1];
            cmd_o.rsel_isr = wdata_i[0];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pic_edge_det.sv
`timescale 1ns/1ps
module pic_edge_det #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] line_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= '0;
    else         line_q <= line_i;
  end

  assign rise_o = line_i & ~line_q;
endmodule

// File: rtl/pic_prio_res.sv
`timescale 1ns/1ps
module pic_prio_res #(
  parameter int N  = 8,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  input  logic [LW-1:0] lowest_i,
  output logic          found_o,
  output logic [LW-1:0] lvl_o,
  output logic [LW-1:0] rank_o
);
  // rank 0 is the level just above lowest_i; scan down so the best rank wins last
  always_comb begin
    found_o = 1'b0;
    lvl_o   = '0;
    rank_o  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (vec_i[LW'(lowest_i + LW'(k + 1))]) begin
        found_o = 1'b1;
        lvl_o   = LW'(lowest_i + LW'(k + 1));
        rank_o  = LW'(k);
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N_LVL = NL,
  localparam int LVW  = $clog2(N_LVL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_LVL-1:0] irq_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             ack_i,
  output logic             int_o,
  output logic [LVW-1:0]   ack_lvl_o
);
  logic [N_LVL-1:0] irr_q, isr_q, imr_q;
  logic [N_LVL-1:0] irr_d, isr_d;
  logic [LVW-1:0]   lowest_q, lowest_d;
  logic             smm_q, poll_q, rsel_isr_q;

  pic_cmd_t         cmd;
  logic [N_LVL-1:0] rise, pending, cand;
  logic             req_found, isr_found, int_w, ack_fire;
  logic [LVW-1:0]   req_lvl, req_rank, isr_lvl, isr_rank;

  pic_cmd_decode u_dec (
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cmd_o   (cmd)
  );

  pic_edge_det #(.N(N_LVL)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (irq_i),
    .rise_o (rise)
  );

  assign pending = irr_q & ~imr_q;
  assign cand    = smm_q ? (pending & ~isr_q) : pending;

  pic_prio_res #(.N(N_LVL)) u_req_res (
    .vec_i    (cand),
    .lowest_i (lowest_q),
    .found_o  (req_found),
    .lvl_o    (req_lvl),
    .rank_o   (req_rank)
  );

  pic_prio_res #(.N(N_LVL)) u_isr_res (
    .vec_i    (isr_q),
    .lowest_i (lowest_q),
    .found_o  (isr_found),
    .lvl_o    (isr_lvl),
    .rank_o   (isr_rank)
  );

  assign int_w    = req_found & (smm_q | ~isr_found | (req_rank < isr_rank));
  assign ack_fire = int_w & (ack_i | (rd_i & poll_q));

  assign int_o     = int_w;
  assign ack_lvl_o = req_lvl;

  always_comb begin
    if (poll_q)      rdata_o = {int_w, {(DW-1-LVW){1'b0}}, int_w ? req_lvl : LVW'(0)};
    else if (addr_i) rdata_o = imr_q;
    else             rdata_o = rsel_isr_q ? isr_q : irr_q;
  end

  always_comb begin
    irr_d    = irr_q;
    isr_d    = isr_q;
    lowest_d = lowest_q;
    if (ack_fire) begin
      irr_d[req_lvl] = 1'b0;
      isr_d[req_lvl] = 1'b1;
    end
    irr_d = irr_d | rise;
    if (cmd.eoi_ns && isr_found) begin
      isr_d[isr_lvl] = 1'b0;
      if (cmd.rot) lowest_d = isr_lvl;
    end
    if (cmd.eoi_sp) begin
      isr_d[cmd.lvl] = 1'b0;
      if (cmd.rot) lowest_d = cmd.lvl;
    end
    if (cmd.set_low) lowest_d = cmd.lvl;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q      <= '0;
      isr_q      <= '0;
      imr_q      <= '0;
      lowest_q   <= LVW'(N_LVL - 1);
      smm_q      <= 1'b0;
      poll_q     <= 1'b0;
      rsel_isr_q <= 1'b0;
    end else begin
      irr_q    <= irr_d;
      isr_q    <= isr_d;
      lowest_q <= lowest_d;
      if (cmd.mask_we) imr_q <= wdata_i[N_LVL-1:0];
      if (cmd.smm_set)      smm_q <= 1'b1;
      else if (cmd.smm_clr) smm_q <= 1'b0;
      if (cmd.poll_arm)           poll_q <= 1'b1;
      else if (rd_i)              poll_q <= 1'b0;
      if (cmd.rsel_we) rsel_isr_q <= cmd.rsel_isr;
    end
  end
endmodule

// File: rtl/pic_checker.sv
`timescale 1ns/1ps
module pic_checker #(
  parameter int N_LVL = 8,
  localparam int LVW  = $clog2(N_LVL)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic             rd_i,
  input logic             addr_i,
  input logic [7:0]       wdata_i,
  input logic             ack_i,
  input logic             int_o,
  input logic [LVW-1:0]   ack_lvl_o,
  input logic [N_LVL-1:0] irr_q,
  input logic [N_LVL-1:0] isr_q,
  input logic [N_LVL-1:0] imr_q,
  input logic [LVW-1:0]   lowest_q,
  input logic             poll_q
);
  assert_mask_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i |=> imr_q == $past(wdata_i[N_LVL-1:0]));

  assert_int_unmasked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> |(irr_q & ~imr_q));

  assert_ack_sets_isr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && int_o && !wr_i |=> isr_q[$past(ack_lvl_o)]);

  assert_spec_eoi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !addr_i && wdata_i[4:3] == 2'b00 && wdata_i[6:5] == 2'b11 &&
    !ack_i && !(rd_i && poll_q) |=> !isr_q[$past(wdata_i[2:0])]);

  assert_noop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !addr_i && wdata_i[4:3] == 2'b00 &&
    (wdata_i[6:5] == 2'b00 || wdata_i[7:5] == 3'b010) && !ack_i && !rd_i
    |=> $stable(isr_q) && $stable(lowest_q) && $stable(imr_q));

  assert_poll_once_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && poll_q && !wr_i |=> !poll_q);
endmodule

bind prio_irq_ctrl pic_checker #(.N_LVL(N_LVL)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .ack_i     (ack_i),
  .int_o     (int_o),
  .ack_lvl_o (ack_lvl_o),
  .irr_q     (irr_q),
  .isr_q     (isr_q),
  .imr_q     (imr_q),
  .lowest_q  (lowest_q),
  .poll_q    (poll_q)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       wr = 1'b0, rd = 1'b0, addr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       int_s;
  logic [2:0] ack_lvl;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ack_i(ack),
    .int_o(int_s), .ack_lvl_o(ack_lvl)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_IRQ = 2'd2, OP_ACK = 2'd3;
  // {req[3:0], op[1:0], addr, data[7:0], exp[7:0], exp_int}
  localparam int NV = 34;
  localparam logic [23:0] VEC [NV] = '{
    {4'd1,  OP_RD,  1'b1, 8'h00, 8'h00, 1'b0}, // R1 mask reads zero
    {4'd2,  OP_WR,  1'b1, 8'hFF, 8'h00, 1'b0}, // R2 mask all
    {4'd3,  OP_IRQ, 1'b0, 8'h05, 8'h00, 1'b0}, // R3 latched while masked
    {4'd3,  OP_RD,  1'b0, 8'h00, 8'h05, 1'b0}, // R3 request reg
    {4'd13, OP_WR,  1'b1, 8'h04, 8'h00, 1'b1}, // R13 line 2 stays masked
    {4'd5,  OP_ACK, 1'b0, 8'h00, 8'h00, 1'b0}, // R5 level 0
    {4'd12, OP_WR,  1'b0, 8'h0B, 8'h00, 1'b0}, // R12 select in-service
    {4'd12, OP_RD,  1'b0, 8'h00, 8'h01, 1'b0},
    {4'd4,  OP_IRQ, 1'b0, 8'h02, 8'h00, 1'b0}, // R4 blocked by higher isr
    {4'd6,  OP_WR,  1'b0, 8'h20, 8'h00, 1'b1}, // R6 ns eoi
    {4'd5,  OP_ACK, 1'b0, 8'h00, 8'h01, 1'b0},
    {4'd4,  OP_WR,  1'b1, 8'h00, 8'h00, 1'b0}, // R4 level 2 below isr 1
    {4'd7,  OP_WR,  1'b0, 8'h61, 8'h00, 1'b1}, // R7 specific eoi 1
    {4'd5,  OP_ACK, 1'b0, 8'h00, 8'h02, 1'b0},
    {4'd6,  OP_WR,  1'b0, 8'hA0, 8'h00, 1'b0}, // R6 rotate ns eoi -> lowest 2
    {4'd8,  OP_IRQ, 1'b0, 8'h84, 8'h00, 1'b1},
    {4'd8,  OP_ACK, 1'b0, 8'h00, 8'h07, 1'b0}, // R8 7 outranks 2
    {4'd10, OP_WR,  1'b0, 8'h68, 8'h00, 1'b1}, // R10 smm on
    {4'd10, OP_ACK, 1'b0, 8'h00, 8'h02, 1'b0},
    {4'd10, OP_WR,  1'b0, 8'h48, 8'h00, 1'b0}, // R10 smm off
    {4'd11, OP_WR,  1'b0, 8'h0C, 8'h00, 1'b0}, // R11 arm poll
    {4'd11, OP_RD,  1'b0, 8'h00, 8'h00, 1'b0}, // R11 nothing due
    {4'd11, OP_RD,  1'b0, 8'h00, 8'h84, 1'b0}, // R11 poll disarmed
    {4'd9,  OP_WR,  1'b0, 8'h00, 8'h00, 1'b0}, // R9 code 000
    {4'd9,  OP_RD,  1'b0, 8'h00, 8'h84, 1'b0},
    {4'd6,  OP_WR,  1'b0, 8'h20, 8'h00, 1'b0}, // R6 clears 7 (rank 4)
    {4'd6,  OP_RD,  1'b0, 8'h00, 8'h04, 1'b0},
    {4'd8,  OP_WR,  1'b0, 8'hC5, 8'h00, 1'b0}, // R8 lowest 5
    {4'd8,  OP_IRQ, 1'b0, 8'h21, 8'h00, 1'b1},
    {4'd11, OP_WR,  1'b0, 8'h0C, 8'h00, 1'b1},
    {4'd11, OP_RD,  1'b0, 8'h00, 8'h80, 1'b0}, // R11 poll level 0
    {4'd7,  OP_WR,  1'b0, 8'hE2, 8'h00, 1'b1}, // R7 rotate specific 2
    {4'd8,  OP_ACK, 1'b0, 8'h00, 8'h05, 1'b0},
    {4'd2,  OP_RD,  1'b1, 8'h00, 8'h00, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic do_rd(input logic a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic do_irq(input logic [7:0] m);
    @(negedge clk); irq = irq | m;
    @(negedge clk); irq = irq & ~m;
  endtask

  task automatic do_ack(output logic [2:0] l);
    @(negedge clk); ack = 1'b1;
    #1 l = ack_lvl;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic apply_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [2:0] l;
    apply_reset();
    chk("R1 int after reset", {7'd0, int_s}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i][23:20], i);
      unique case (VEC[i][19:18])
        OP_WR:  do_wr(VEC[i][17], VEC[i][16:9]);
        OP_RD:  begin do_rd(VEC[i][17], d); chk({tag, " rdata"}, d, VEC[i][8:1]); end
        OP_IRQ: do_irq(VEC[i][16:9]);
        OP_ACK: begin do_ack(l); chk({tag, " ack_lvl"}, {5'd0, l}, VEC[i][8:1]); end
      endcase
      chk({tag, " int"}, {7'd0, int_s}, {7'd0, VEC[i][0]});
    end

    // R1: reset mid-run restores defaults
    apply_reset();
    chk("R1 int", {7'd0, int_s}, 8'h00);
    do_rd(1'b1, d); chk("R1 mask", d, 8'h00);
    do_rd(1'b0, d); chk("R1 request sel", d, 8'h00);
    do_wr(1'b0, 8'h0B);
    do_rd(1'b0, d); chk("R1 isr", d, 8'h00);
    do_wr(1'b0, 8'h0A);

    // R1: level 0 highest by default
    do_irq(8'h81);
    do_ack(l); chk("R1 default order", {5'd0, l}, 8'h00);
    chk("R4 7 blocked by 0", {7'd0, int_s}, 8'h00);
    do_wr(1'b0, 8'h20);
    do_ack(l); chk("R5 level 7", {5'd0, l}, 8'h07);
    // R9: codes 100 and 010 change nothing
    do_wr(1'b0, 8'h80);
    do_wr(1'b0, 8'h40);
    do_wr(1'b0, 8'h18); // R9 bits 4:3 = 11 ignored
    do_wr(1'b0, 8'h0B);
    do_rd(1'b0, d); chk("R9 isr kept", d, 8'h80);
    do_wr(1'b0, 8'h20);
    do_rd(1'b0, d); chk("R6 isr cleared", d, 8'h00);
    do_wr(1'b0, 8'h0A);

    // R13: downstream line blocked by mask bit 2
    do_wr(1'b1, 8'h04);
    do_irq(8'h04);
    chk("R13 blocked", {7'd0, int_s}, 8'h00);
    do_rd(1'b0, d); chk("R3 latched masked", d, 8'h04);
    do_wr(1'b1, 8'h00);
    chk("R13 unmasked int", {7'd0, int_s}, 8'h01);
    do_ack(l); chk("R5 ack 2", {5'd0, l}, 8'h02);

    // R3: held line raises one request only
    @(negedge clk); irq = 8'h08;
    @(negedge clk);
    chk("R4 3 below isr 2", {7'd0, int_s}, 8'h00);
    do_wr(1'b0, 8'h62);
    chk("R7 after eoi 2", {7'd0, int_s}, 8'h01);
    do_ack(l); chk("R5 ack 3", {5'd0, l}, 8'h03);
    do_wr(1'b0, 8'h20);
    repeat (2) @(negedge clk);
    chk("R3 held no rerequest", {7'd0, int_s}, 8'h00);
    do_rd(1'b0, d); chk("R3 request clear", d, 8'h00);
    irq = 8'h00;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule